// File: doc/BRIEF.md
# CEC Header Address Filter and Acknowledge Decision

This block sits behind the bit-level receiver of a CEC node and looks only at the first byte of every incoming frame. It pulls apart the initiator and destination nibbles, then decides two things: whether the frame is captured, and whether this node pulls the acknowledge slot low. The node can answer to several logical addresses at once. A one-hot map marks them, with bit i standing for logical address i.

A listen-all control selects how foreign traffic is handled. With it clear, only frames for one of the node's own addresses and broadcast frames are taken. With it set, frames for any other destination are captured too, but the node never acknowledges them. Broadcast frames are always captured. After the header, the block counts the bytes that follow. A frame longer than sixteen bytes, header included, is marked as overrun. From then on the acknowledge decision refuses every further byte. All decisions are registered, so they are stable well before the acknowledge slot.

Top module: `cec_hdr_filter`

## Requirements
- R1: One cycle after `hdr_valid`, `initiator` equals header bits 7:4 and `destination` equals header bits 3:0.
- R2: A header whose destination d (not 15) has `own_map[d]` set gives `accept`=1 and `ack_low`=1 one cycle later.
- R3: With `listen_all`=0, a header for a destination that is neither 15 nor in `own_map` gives `accept`=0 and `ack_low`=0. The frame's `byte_end` strobes are ignored, so `overrun` stays 0.
- R4: With `listen_all`=1, a header for a foreign destination gives `accept`=1. `ack_low` stays 0 for that whole frame, including after every `byte_end`.
- R5: Destination 15 is broadcast. It gives `accept`=1, `broadcast`=1 and `ack_low`=0, whatever `listen_all` and `own_map` are.
- R6: With `own_map` all zero, no destination is acknowledged, and broadcast frames are still captured.
- R7: Several bits of `own_map` may be set at once, and each of those addresses is acknowledged independently.
- R8: In a captured frame, the header and up to 15 following bytes (each marked by one `byte_end`) leave `overrun`=0. The next `byte_end` sets `overrun`=1 one cycle later, and `overrun` holds until the next header.
- R9: Once a frame is overrun, `ack_low` goes to 0 for a directly addressed frame (refusal) and to 1 for a broadcast frame (rejection). In the same cycle, `overrun` becomes 1.
- R10: `frame_end` clears `accept` and `ack_low` one cycle later. `broadcast`, `initiator`, `destination` and `overrun` keep their values until the next header.
- R11: After reset, every output is 0.
- R12: When `hdr_valid` and `frame_end` arrive in the same cycle, the header wins and the new frame's decision is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | One-cycle strobe: `hdr_byte` holds a frame header |
| hdr_byte | input | 8 | Header byte: initiator in 7:4, destination in 3:0 |
| own_map | input | 15 | One-hot own-address map, bit i = logical address i |
| listen_all | input | 1 | 1: also capture foreign frames silently |
| byte_end | input | 1 | One-cycle strobe at the end of each byte after the header |
| frame_end | input | 1 | One-cycle strobe at the end of the frame |
| accept | output | 1 | Current frame is captured |
| ack_low | output | 1 | Drive the acknowledge slot low |
| broadcast | output | 1 | Current frame is a broadcast |
| overrun | output | 1 | Frame exceeded the maximum length and is truncated |
| initiator | output | 4 | Initiator address of the latest header |
| destination | output | 4 | Destination address of the latest header |

## Verification
Several checks run every cycle. They cover the header-to-decision relations for a direct match, for broadcast and for an ignored foreign header. They also check that the acknowledge is never driven without capture, that overrun stays set until the next header, that the frame end clears its outputs, and the refusal polarity on the overrun edge. Other behaviours need whole scenarios from the bench. These are the exact byte count at which overrun starts, that strobes in an ignored frame change nothing, and that fields are held across the frame end. The bench also covers the listen and own-map combinations, including several own addresses and an empty map.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;
  localparam int ADDR_W   = 4;
  localparam int NUM_OWN  = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W-1:0] BCAST = ADDR_W'(NUM_OWN);

  function automatic logic [ADDR_W-1:0] hdr_src(input logic [2*ADDR_W-1:0] h);
    return h[2*ADDR_W-1:ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_dst(input logic [2*ADDR_W-1:0] h);
    return h[ADDR_W-1:0];
  endfunction

  // True when map marks address d; the broadcast code never matches.
  function automatic logic own_hit(input logic [NUM_OWN-1:0] map,
                                   input logic [ADDR_W-1:0] d);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_OWN; i++)
      if (d == ADDR_W'(i)) r = map[i];
    return r;
  endfunction
endpackage

// File: rtl/cec_hdr_decode.sv
module cec_hdr_decode
  import cec_filt_pkg::*;
(
  input  logic [2*ADDR_W-1:0] hdr,
  input  logic [NUM_OWN-1:0]  own_map,
  input  logic                listen_all,
  output logic [ADDR_W-1:0]   src,
  output logic [ADDR_W-1:0]   dst,
  output logic                is_bcast,
  output logic                hit,
  output logic                keep
);
  always_comb begin
    src      = hdr_src(hdr);
    dst      = hdr_dst(hdr);
    is_bcast = (dst == BCAST);
    hit      = own_hit(own_map, dst);
    keep     = hit | is_bcast | listen_all;
  end
endmodule

// File: rtl/cec_frame_len.sv
module cec_frame_len #(
  parameter int MAX_BYTES = 16,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic count_en,
  output logic ovf_next,
  output logic overrun
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(MAX_BYTES));
  assign ovf_next = overrun | (count_en & at_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      overrun <= 1'b0;
    end else if (start) begin
      cnt_q   <= CNT_W'(1);
      overrun <= 1'b0;
    end else if (count_en) begin
      if (at_limit) overrun <= 1'b1;
      else          cnt_q   <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cec_hdr_filter.sv
module cec_hdr_filter
  import cec_filt_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_valid,
  input  logic [7:0]          hdr_byte,
  input  logic [14:0]         own_map,
  input  logic                listen_all,
  input  logic                byte_end,
  input  logic                frame_end,
  output logic                accept,
  output logic                ack_low,
  output logic                broadcast,
  output logic                overrun,
  output logic [3:0]          initiator,
  output logic [3:0]          destination
);
  logic [ADDR_W-1:0] d_src, d_dst;
  logic d_bcast, d_hit, d_keep;
  logic hit_q;
  logic byte_en;
  logic ovf_next;

  cec_hdr_decode u_dec (
    .hdr(hdr_byte), .own_map(own_map), .listen_all(listen_all),
    .src(d_src), .dst(d_dst), .is_bcast(d_bcast), .hit(d_hit), .keep(d_keep)
  );

  assign byte_en = byte_end & accept & ~hdr_valid & ~frame_end;

  cec_frame_len #(.MAX_BYTES(MAX_BYTES)) u_len (
    .clk(clk), .rst_n(rst_n), .start(hdr_valid), .count_en(byte_en),
    .ovf_next(ovf_next), .overrun(overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept      <= 1'b0;
      ack_low     <= 1'b0;
      hit_q       <= 1'b0;
      broadcast   <= 1'b0;
      initiator   <= '0;
      destination <= '0;
    end else if (hdr_valid) begin
      accept      <= d_keep;
      ack_low     <= d_hit;
      hit_q       <= d_hit;
      broadcast   <= d_bcast;
      initiator   <= d_src;
      destination <= d_dst;
    end else if (frame_end) begin
      accept  <= 1'b0;
      ack_low <= 1'b0;
      hit_q   <= 1'b0;
    end else if (byte_en) begin
      if (hit_q)          ack_low <= ~ovf_next;
      else if (broadcast) ack_low <= ovf_next;
      else                ack_low <= 1'b0;
    end
  end
endmodule

// File: rtl/cec_hdr_filter_chk.sv
module cec_hdr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic [7:0]  hdr_byte,
  input logic [14:0] own_map,
  input logic        listen_all,
  input logic        frame_end,
  input logic        accept,
  input logic        ack_low,
  input logic        broadcast,
  input logic        overrun,
  input logic [3:0]  destination,
  input logic        ovf_next
);
  logic [15:0] ext_map;
  logic        mine, foreign;
  assign ext_map = {1'b0, own_map};
  assign mine    = ext_map[hdr_byte[3:0]];
  assign foreign = (hdr_byte[3:0] != 4'hF) && !mine;

  assert_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> destination == $past(hdr_byte[3:0]));
  assert_direct_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && mine) |=> (accept && ack_low));
  assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && foreign && !listen_all) |=> (!accept && !ack_low));
  assert_ack_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_low |-> accept);
  assert_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_byte[3:0] == 4'hF) |=> (accept && broadcast && !ack_low));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !hdr_valid) |=> overrun);
  assert_ovf_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_next && !hdr_valid) |=> overrun);
  assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(overrun) && accept) |-> (ack_low == broadcast));
  assert_end_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hdr_valid) |=> (!accept && !ack_low));
endmodule

bind cec_hdr_filter cec_hdr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
  .own_map(own_map), .listen_all(listen_all), .frame_end(frame_end),
  .accept(accept), .ack_low(ack_low), .broadcast(broadcast),
  .overrun(overrun), .destination(destination), .ovf_next(ovf_next)
);

// File: tb/test_cec_hdr_filter.sv
module test_cec_hdr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, listen_all = 1'b0, byte_end = 1'b0, frame_end = 1'b0;
  logic [7:0]  hdr_byte = '0;
  logic [14:0] own_map = '0;
  logic accept, ack_low, broadcast, overrun;
  logic [3:0] initiator, destination;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cec_hdr_filter i_cec_hdr_filter (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
    .own_map(own_map), .listen_all(listen_all), .byte_end(byte_end),
    .frame_end(frame_end), .accept(accept), .ack_low(ack_low),
    .broadcast(broadcast), .overrun(overrun), .initiator(initiator),
    .destination(destination)
  );

  // {listen_all, own_map, header, accept, ack_low, broadcast}
  localparam int VW = 27;
  localparam int NV = 9;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 15'h0010, 8'h34, 3'b110},  // R2 own address 4
    {1'b0, 15'h0010, 8'h35, 3'b000},  // R3 foreign, reduced listen
    {1'b1, 15'h0010, 8'h35, 3'b100},  // R4 foreign, listen all
    {1'b0, 15'h0010, 8'h4F, 3'b101},  // R5 broadcast
    {1'b1, 15'h0000, 8'h0F, 3'b101},  // R6 empty map broadcast
    {1'b0, 15'h0000, 8'h10, 3'b000},  // R6 empty map never acks
    {1'b0, 15'h4101, 8'h2E, 3'b110},  // R7 address 14
    {1'b0, 15'h4101, 8'h28, 3'b110},  // R7 address 8
    {1'b0, 15'h4101, 8'h27, 3'b000}   // R7 address 7 not owned
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_hdr(input logic [7:0] h);
    @(negedge clk); hdr_byte = h; hdr_valid = 1'b1;
    @(posedge clk); @(negedge clk); hdr_valid = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); byte_end = 1'b1;
      @(posedge clk); @(negedge clk); byte_end = 1'b0;
    end
  endtask

  task automatic end_frame;
    @(negedge clk); frame_end = 1'b1;
    @(posedge clk); @(negedge clk); frame_end = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {6'd0, accept, ack_low, broadcast, overrun, initiator, destination}, 16'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      listen_all = VEC[v][26];
      own_map    = VEC[v][25:11];
      send_hdr(VEC[v][10:3]);
      chk("R2/R3/R4/R5/R6/R7 decision", {13'd0, accept, ack_low, broadcast}, {13'd0, VEC[v][2:0]});
      chk("R1 fields", {8'd0, initiator, destination}, {8'd0, VEC[v][10:7], VEC[v][6:3]});
      end_frame();
    end

    // R8/R9 direct frame length limit
    listen_all = 1'b0; own_map = 15'h0010;
    send_hdr(8'h34);
    send_bytes(15);
    chk("R8 fifteen bytes no overrun", {14'd0, overrun, ack_low}, 16'd1);
    send_bytes(1);
    chk("R8 sixteenth byte overrun", {15'd0, overrun}, 16'd1);
    chk("R9 direct refusal", {15'd0, ack_low}, 16'd0);
    end_frame();

    // R9 broadcast rejection
    send_hdr(8'h1F);
    send_bytes(15);
    chk("R9 broadcast before limit", {14'd0, overrun, ack_low}, 16'd0);
    send_bytes(1);
    chk("R9 broadcast reject", {14'd0, overrun, ack_low}, 16'd3);

    // R10 frame end clears decision, holds fields
    end_frame();
    chk("R10 cleared", {14'd0, accept, ack_low}, 16'd0);
    chk("R10 held", {5'd0, broadcast, overrun, 1'b0, initiator, destination}, {5'd0, 1'b1, 1'b1, 1'b0, 4'h1, 4'hF});

    // R3 ignored frame: byte strobes have no effect
    send_hdr(8'h35);
    send_bytes(20);
    chk("R3 ignored bytes", {13'd0, accept, ack_low, overrun}, 16'd0);
    end_frame();

    // R4 listen-all foreign frame never acks
    listen_all = 1'b1;
    send_hdr(8'h35);
    send_bytes(3);
    chk("R4 silent capture", {14'd0, accept, ack_low}, 16'd2);
    listen_all = 1'b0;

    // R12 header and frame end together
    @(negedge clk); hdr_byte = 8'h54; hdr_valid = 1'b1; frame_end = 1'b1;
    @(posedge clk); @(negedge clk); hdr_valid = 1'b0; frame_end = 1'b0;
    chk("R12 header wins", {11'd0, accept, ack_low, overrun, 2'd0}, {11'd0, 1'b1, 1'b1, 1'b0, 2'd0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule